// File: doc/BRIEF.md
# Density-Selectable Write Clock Generator

This block derives the data-rate write clock for a magnetic tape controller from a single master clock. The nominal master clock is 3.84 MHz. A free-running prescaler divides it by four to make a 960 kHz reference tick. The prescaler also makes a 240 kHz square-wave clock that the controller uses for its housekeeping timing.

The write clock is produced by an 8-bit reloadable up-counter. It advances once per reference tick, starting from a preset equal to minus n in two's complement. The count then climbs to zero, which is the overflow state. On the tick after overflow the counter takes a fresh preset. The write clock therefore runs at 960/(n+1) kHz, and its high time is the one reference period the counter spends at zero.

The preset comes from a small computed table. When the drive is on-line, the table is addressed by the controller's 3-bit density code. When the drive is off-line, it is addressed by two local test inputs. A new preset is captured only at reload, so a code change never shortens or stretches the period in progress.

Top module: `wclk_gen`

## Requirements
- R1: The control clock `ctl_clk` is a square wave with a period of 16 master cycles. It is low during reset. At the k-th falling master edge after reset is released (k = 0 first), it equals bit 3 of (k+1). The reference tick falls on one master cycle in every four.
- R2: The write clock `wclk` has a period of exactly 4·(n+1) master cycles. It stays high for exactly 4 master cycles in each period.
- R3: When `online` is 1, n follows `dens_sel`: 000→63 (15 kHz), 001→22 (41.7 kHz), 010→15, 011→15 and 110→15 (60 kHz), 100→3 and 111→3 (240 kHz), 101→4 (192 kHz).
- R4: When `online` is 0, n follows {`test_pe`,`test_den`}: 00→54 (about 17.5 kHz), 01→15 (60 kHz), 10→4 (192 kHz), 11→63 (15 kHz).
- R5: When `online` is 0, `dens_sel` has no effect on the period or the preset. When `online` is 1, `test_pe` and `test_den` have no effect on either.
- R6: A change of the selection inputs takes effect only at the next reload. The period in progress completes with its old length, and `preset_sel` keeps its old value until that reload.
- R7: Synchronous reset (`rst` high at a rising edge) loads the counter and `preset_sel` with the preset for the current selection, and holds `wclk` and `ctl_clk` low. After release, the first sample of `wclk` high is at falling master edge 4n−1, counting from 0 at the first falling edge after release.
- R8: `preset_sel` shows the preset in use as an 8-bit two's-complement value, 256−n. After a period ends, the counter restarts from that value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock (nominal 3.84 MHz) |
| rst | input | 1 | Synchronous reset, active high |
| online | input | 1 | 1 selects the density code, 0 selects the test inputs |
| dens_sel | input | 3 | Density code from the controller |
| test_pe | input | 1 | Off-line test input, high-order select bit |
| test_den | input | 1 | Off-line test input, low-order select bit |
| wclk | output | 1 | Write clock, high for one reference period per cycle |
| ctl_clk | output | 1 | Free-running control clock, master/16 |
| preset_sel | output | 8 | Preset currently loaded, equal to 256−n |

## Verification
After reset release, the first `wclk` high sample is due at falling edge 4n−1. From then on, rising samples come every 4·(n+1) edges, and each high run lasts 4 edges. `ctl_clk` is checked against the edge index at every falling edge over two full periods. After a selection change, the bench first waits for one `wclk` rise and only then measures the period, since the reload that follows that rise is the first to use the new code. The mid-count change test counts from the last rise, so it can show that the period in progress keeps its old length. It also checks `preset_sel` one edge after the change, before the reload can occur.

// File: rtl/wclk_pkg.sv
package wclk_pkg;

    // Selection inputs gathered into one word
    typedef struct packed {
        logic       online;
        logic [2:0] dens;
        logic       tpe;
        logic       tden;
    } sel_t;

    // Divide value n; the write clock runs at ref/(n+1)
    function automatic int unsigned wclk_ratio(sel_t s);
        int unsigned n;
        if (s.online) begin
            case (s.dens)
                3'd0:    n = 63;
                3'd1:    n = 22;
                3'd2:    n = 15;
                3'd3:    n = 15;
                3'd4:    n = 3;
                3'd5:    n = 4;
                3'd6:    n = 15;
                default: n = 3;
            endcase
        end else begin
            case ({s.tpe, s.tden})
                2'd0:    n = 54;
                2'd1:    n = 15;
                2'd2:    n = 4;
                default: n = 63;
            endcase
        end
        return n;
    endfunction

endpackage

// File: rtl/wclk_prescale.sv
module wclk_prescale #(
    parameter int REF_DIV  = 4,
    parameter int CTL_LOG2 = 4
) (
    input  logic clk,
    input  logic rst,
    output logic ref_tick,
    output logic ctl_clk
);
    localparam int PRE_W = (REF_DIV > 2) ? $clog2(REF_DIV) : 1;
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(REF_DIV - 1);

    typedef struct packed {
        logic [PRE_W-1:0]    pre;
        logic [CTL_LOG2-1:0] ctl;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rst) begin
            st_d = '0;
        end else begin
            if (st_q.pre == PRE_LAST) st_d.pre = '0;
            else                      st_d.pre = st_q.pre + 1'b1;
            st_d.ctl = st_q.ctl + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign ref_tick = (st_q.pre == PRE_LAST);
    assign ctl_clk  = st_q.ctl[CTL_LOG2-1];

    // R1: reference ticks never fall on adjacent cycles
    a_r1_tick_gap: assert property (@(posedge clk) disable iff (rst)
        ref_tick |=> !ref_tick);

endmodule

// File: rtl/wclk_preset_lut.sv
module wclk_preset_lut
    import wclk_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  sel_t             sel,
    output logic [CNT_W-1:0] preset
);
    logic [CNT_W-1:0] n_w;

    always_comb begin
        n_w    = CNT_W'(wclk_ratio(sel));
        preset = CNT_W'(0) - n_w;
    end

endmodule

// File: rtl/wclk_rate_cnt.sv
module wclk_rate_cnt #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ref_tick,
    input  logic [CNT_W-1:0] preset_in,
    output logic             wclk,
    output logic [CNT_W-1:0] active
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] act;
        logic             wclk;
    } st_t;

    st_t st_d, st_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] act_q;

    always_comb begin
        st_d = st_q;
        if (rst) begin
            st_d.cnt = preset_in;
            st_d.act = preset_in;
        end else if (ref_tick) begin
            if (st_q.cnt == '0) begin
                st_d.cnt = preset_in;
                st_d.act = preset_in;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
        st_d.wclk = !rst && (st_d.cnt == '0);
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign cnt_q  = st_q.cnt;
    assign act_q  = st_q.act;
    assign wclk   = st_q.wclk;
    assign active = st_q.act;

    // R2: the write clock only falls on a reference tick
    a_r2_hold_high: assert property (@(posedge clk) disable iff (rst)
        (wclk && !ref_tick) |=> wclk);

    // R2: each tick below overflow advances the count by one
    a_r2_step: assert property (@(posedge clk) disable iff (rst)
        (ref_tick && cnt_q != '0) |=> (cnt_q == CNT_W'($past(cnt_q) + 1'b1)));

    // R6: the active preset is held unless a reload happens
    a_r6_act_hold: assert property (@(posedge clk) disable iff (rst)
        (!ref_tick || cnt_q != '0) |=> $stable(act_q));

    // R8: on wrap the counter restarts from the captured preset, clock low
    a_r8_wrap_load: assert property (@(posedge clk) disable iff (rst)
        (ref_tick && cnt_q == '0) |=> (cnt_q == act_q && !wclk));

endmodule

// File: rtl/wclk_gen.sv
module wclk_gen
    import wclk_pkg::*;
#(
    parameter int REF_DIV  = 4,
    parameter int CTL_LOG2 = 4,
    parameter int CNT_W    = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             online,
    input  logic [2:0]       dens_sel,
    input  logic             test_pe,
    input  logic             test_den,
    output logic             wclk,
    output logic             ctl_clk,
    output logic [CNT_W-1:0] preset_sel
);
    sel_t             sel;
    logic             ref_tick;
    logic [CNT_W-1:0] lut_preset;

    assign sel = '{online: online, dens: dens_sel, tpe: test_pe, tden: test_den};

    wclk_prescale #(.REF_DIV(REF_DIV), .CTL_LOG2(CTL_LOG2)) u_pre (
        .clk      (clk),
        .rst      (rst),
        .ref_tick (ref_tick),
        .ctl_clk  (ctl_clk)
    );

    wclk_preset_lut #(.CNT_W(CNT_W)) u_lut (
        .sel    (sel),
        .preset (lut_preset)
    );

    wclk_rate_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk       (clk),
        .rst       (rst),
        .ref_tick  (ref_tick),
        .preset_in (lut_preset),
        .wclk      (wclk),
        .active    (preset_sel)
    );

    // R7: outputs are quiet in the cycle after a reset edge
    a_r7_reset_quiet: assert property (@(posedge clk)
        rst |=> (!wclk && !ctl_clk));

endmodule

// File: tb/wclk_gen_tb.sv
module wclk_gen_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       online = 1'b1;
    logic [2:0] dens_sel = 3'd0;
    logic       test_pe = 1'b0;
    logic       test_den = 1'b0;
    logic       wclk;
    logic       ctl_clk;
    logic [7:0] preset_sel;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    wclk_gen u_dut (
        .clk(clk), .rst(rst), .online(online), .dens_sel(dens_sel),
        .test_pe(test_pe), .test_den(test_den),
        .wclk(wclk), .ctl_clk(ctl_clk), .preset_sel(preset_sel)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    // Wait until a 0->1 transition of wclk is seen at a falling edge
    task automatic sync_rise();
        logic prev;
        prev = wclk;
        for (int i = 0; i < 2000; i++) begin
            @(negedge clk);
            if (!prev && wclk) break;
            prev = wclk;
        end
    endtask

    // Measure high width and rise-to-rise period from a fresh rise
    task automatic period_check(input int n, input string tag);
        int hi;
        int per;
        logic prev;
        sync_rise();
        hi = 0;
        per = 0;
        prev = wclk;
        if (wclk) hi = 1;
        for (int i = 0; i < 2000; i++) begin
            @(negedge clk);
            per++;
            if (!prev && wclk) break;
            if (wclk && hi == per) hi++;
            prev = wclk;
        end
        check(per == 4 * (n + 1), {tag, " period"}, per, 4 * (n + 1));
        check(hi == 4, "R2 high width", hi, 4);
        check(preset_sel == 8'(256 - n), {tag, " preset R8"}, preset_sel, 256 - n);
    endtask

    task automatic t_reset();
        int c;
        online = 1'b1; dens_sel = 3'd4;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check(wclk == 1'b0, "R7 wclk in reset", wclk, 0);
        check(ctl_clk == 1'b0, "R7 ctl_clk in reset", ctl_clk, 0);
        check(preset_sel == 8'd253, "R7 preset in reset", preset_sel, 253);
        rst = 1'b0;
        c = 0;
        for (int i = 0; i < 1000; i++) begin
            @(negedge clk);
            if (wclk) break;
            c++;
        end
        check(c == 11, "R7 first rise", c, 11);
    endtask

    task automatic t_ctl();
        int bad;
        int first_bad;
        bad = 0;
        first_bad = -1;
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        for (int k = 0; k < 32; k++) begin
            @(negedge clk);
            if (ctl_clk != (((k + 1) >> 3) & 1)) begin
                bad++;
                if (first_bad < 0) first_bad = k;
            end
        end
        check(bad == 0, "R1 ctl_clk pattern", first_bad, -1);
    endtask

    task automatic t_online();
        int tbl[8] = '{63, 22, 15, 15, 3, 4, 15, 3};
        online = 1'b1;
        for (int c = 0; c < 8; c++) begin
            dens_sel = 3'(c);
            test_pe = c[0];
            test_den = c[1];
            period_check(tbl[c], "R3 online");
        end
        // R5: test inputs ignored while on-line
        dens_sel = 3'd5;
        test_pe = 1'b1; test_den = 1'b1;
        period_check(4, "R5 test ignored");
        test_pe = 1'b0; test_den = 1'b0;
        period_check(4, "R5 test ignored");
    endtask

    task automatic t_offline();
        int tbl[4] = '{54, 15, 4, 63};
        online = 1'b0;
        for (int c = 0; c < 4; c++) begin
            {test_pe, test_den} = 2'(c);
            dens_sel = 3'(7 - c);
            period_check(tbl[c], "R4 offline");
        end
        // R5: density code ignored while off-line
        {test_pe, test_den} = 2'b10;
        dens_sel = 3'd0;
        period_check(4, "R5 dens ignored");
        dens_sel = 3'd4;
        period_check(4, "R5 dens ignored");
        online = 1'b1;
    endtask

    task automatic t_midchange();
        int per;
        logic prev;
        online = 1'b1;
        dens_sel = 3'd0;
        period_check(63, "R6 setup");
        sync_rise();
        per = 0;
        prev = wclk;
        repeat (20) begin
            @(negedge clk);
            per++;
            prev = wclk;
        end
        dens_sel = 3'd4;
        @(negedge clk);
        per++;
        prev = wclk;
        check(preset_sel == 8'd193, "R6 preset held", preset_sel, 193);
        for (int i = 0; i < 2000; i++) begin
            @(negedge clk);
            per++;
            if (!prev && wclk) break;
            prev = wclk;
        end
        check(per == 256, "R6 old period completes", per, 256);
        period_check(3, "R6 new code");
    endtask

    initial begin
        do_reset();
        t_reset();
        t_ctl();
        t_online();
        t_offline();
        t_midchange();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 150000; i++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule